// File: doc/BRIEF.md
# Dual-Channel Reset/Load Command Decoder

This block takes control bytes written on an 8-bit bus and turns them into one-cycle action strobes for two counter channels, X (channel 0) and Y (channel 1). Each channel holds a 24-bit counter, a 24-bit output latch and an 8-bit filter-clock prescaler. The 24-bit preset value of each channel comes in on a port. Byte-pointer and flag resets are not applied here. They leave the block as strobes for the neighbouring logic that owns that state.

One write carries a group code, a broadcast bit and three independent action fields. The fields cover the byte pointer, the counter and flag resets, and the data transfers. A write goes to the channel named by the `sel_y` pin, or to both channels when the broadcast bit is set. The prescaler divides a filter tick by a factor taken from the low byte of the preset value. It gives a one-cycle enable each time it wraps.

Top module: `dual_rld_ctrl`

## Requirements
- R1: A write whose bits 6:5 are not 00 is ignored. It raises no strobe and changes no counter, latch or prescaler.
- R2: If bit 7 is 0, a write acts only on the channel picked by `sel_y` (0 = X / channel 0, 1 = Y / channel 1). If bit 7 is 1, it acts on both channels and `sel_y` is ignored.
- R3: Bit 0 = 1 raises the byte-pointer reset strobe, which is `act_q` bit 0.
- R4: Bits 2:1 select a reset. 01 raises `act_q` bit 1 and clears the counter to zero. 10 raises `act_q` bit 2 (clear the borrow/carry/compare/sign flags). 11 raises `act_q` bit 3 (clear the error flag). 00 does nothing.
- R5: Bits 4:3 select a transfer. 01 raises `act_q` bit 4 (preset to counter). 10 raises `act_q` bit 5 (counter to latch). 11 raises `act_q` bit 6 (preset bits 7:0 to the prescaler). 00 does nothing.
- R6: The preset-to-counter transfer loads all 24 bits at one clock edge. A counter reset in the same write wins over the transfer. Either one wins over a `step` at that edge.
- R7: The counter-to-latch transfer stores the counter value held just before the write edge, even if the same write also resets or loads the counter.
- R8: When more than one action field is nonzero, all of them take effect at the same edge.
- R9: Strobes are registered. They are high for exactly the one cycle after the edge that samples the write, and are zero otherwise.
- R10: After a load of n, `fen` pulses once every n+1 `fck_tick` edges. The pulse is high in the cycle after a tick edge at which the down-count was zero, and the count then reloads to n. A load edge clears the count to n and gives no pulse.
- R11: After a synchronous reset, all counters, latches, strobes and enables are zero, and the prescaler factor and count are zero.
- R12: With no reset or load requested, a high `step` bit increments that channel's counter by one, modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command byte valid this cycle |
| wr_data | input | 8 | Command byte |
| sel_y | input | 1 | Channel select for non-broadcast writes (1 = Y) |
| step | input | 2 | Per-channel counter increment request |
| fck_tick | input | 1 | Filter clock tick shared by both prescalers |
| preset | input | 2x24 | Per-channel preset value |
| act_q | output | 2x7 | Per-channel action strobes |
| cntr_q | output | 2x24 | Per-channel counter |
| latch_q | output | 2x24 | Per-channel output latch |
| fen | output | 2 | Per-channel filter clock enable |

## Verification
The bench targets these cases:
- A write that both resets the counter and moves it to the latch. A design that samples the counter too late would latch zero.
- A write that combines a reset with a preset load. Wrong priority would leave the preset value in the counter.
- A load request at the same edge as a `step`.
- Group codes other than 00. A partial decode would fire strobes on them.
- A broadcast write made while `sel_y` points at the other channel.
- A prescaler run with a small factor, where the pulses are counted. An off-by-one reload would give the wrong number of pulses over nine ticks.

// File: rtl/dual_rld_pkg.sv
// Shared types for the dual-channel reset/load decoder.
// Assumes two channels and a fixed 7-strobe action set.
package dual_rld_pkg;
    localparam int NCH     = 2;
    localparam int NUM_ACT = 7;

    // Reset field encoding (command bits 2:1)
    typedef enum logic [1:0] {
        RST_NONE  = 2'b00,
        RST_CNTR  = 2'b01,
        RST_FLAGS = 2'b10,
        RST_ERR   = 2'b11
    } rst_sel_e;

    // Transfer field encoding (command bits 4:3)
    typedef enum logic [1:0] {
        XFR_NONE   = 2'b00,
        XFR_PR2CNT = 2'b01,
        XFR_CNT2OL = 2'b10,
        XFR_PR2PSC = 2'b11
    } xfr_sel_e;

    // Action strobes, MSB first: bit 6 ld_psc ... bit 0 clr_bp
    typedef struct packed {
        logic ld_psc;
        logic ld_latch;
        logic ld_cntr;
        logic clr_err;
        logic clr_flags;
        logic clr_cntr;
        logic clr_bp;
    } act_t;
endpackage

// File: rtl/dual_rld_decode.sv
// Combinational command decoder.
// Maps one command byte to per-channel action structs.
// Assumes the command byte is only looked at while wr_en is high.
module dual_rld_decode
    import dual_rld_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                sel_y,
    output act_t [NCH-1:0]      act
);
    localparam int GRP_LO = 5;
    localparam int BC_BIT = 7;

    logic     grp_hit;
    rst_sel_e rst_sel;
    xfr_sel_e xfr_sel;

    // Recognise this register group and split out the fields
    always_comb begin
        grp_hit = wr_en && (wr_data[GRP_LO+1:GRP_LO] == 2'b00);
        rst_sel = rst_sel_e'(wr_data[2:1]);
        xfr_sel = xfr_sel_e'(wr_data[4:3]);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        // Channel is addressed by broadcast or by the select pin
        always_comb begin
            hit              = grp_hit && (wr_data[BC_BIT] || (sel_y == 1'(c)));
            act[c]           = '0;
            act[c].clr_bp    = hit && wr_data[0];
            act[c].clr_cntr  = hit && (rst_sel == RST_CNTR);
            act[c].clr_flags = hit && (rst_sel == RST_FLAGS);
            act[c].clr_err   = hit && (rst_sel == RST_ERR);
            act[c].ld_cntr   = hit && (xfr_sel == XFR_PR2CNT);
            act[c].ld_latch  = hit && (xfr_sel == XFR_CNT2OL);
            act[c].ld_psc    = hit && (xfr_sel == XFR_PR2PSC);
        end
    end
endmodule

// File: rtl/dual_rld_chan.sv
// Per-channel counter and output latch.
// Counter priority: clear, then preset load, then step.
// The latch captures the counter value from before the edge.
module dual_rld_chan
    import dual_rld_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_t          act,
    input  logic          step,
    input  logic [CW-1:0] preset,
    output logic [CW-1:0] cntr_q,
    output logic [CW-1:0] latch_q
);
    // Counter update with clear/load/step priority
    always_ff @(posedge clk) begin
        if (!rst_n)            cntr_q <= '0;
        else if (act.clr_cntr) cntr_q <= '0;
        else if (act.ld_cntr)  cntr_q <= preset;
        else if (step)         cntr_q <= cntr_q + CW'(1);
    end

    // Parallel capture of the counter into the latch
    always_ff @(posedge clk) begin
        if (!rst_n)            latch_q <= '0;
        else if (act.ld_latch) latch_q <= cntr_q;
    end
endmodule

// File: rtl/dual_rld_prescale.sv
// Modulo-(n+1) down counter that makes the filter clock enable.
// The factor n is loaded by command; the count moves only on tick.
// The enable is high for one cycle after each wrap from zero.
module dual_rld_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          tick,
    output logic          fen
);
    logic [PW-1:0] n_q;
    logic [PW-1:0] cnt_q;

    // Hold the divide factor
    always_ff @(posedge clk) begin
        if (!rst_n)    n_q <= '0;
        else if (load) n_q <= load_val;
    end

    // Count down on tick, reload and pulse at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            fen   <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            fen   <= 1'b0;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q <= n_q;
                fen   <= 1'b1;
            end else begin
                cnt_q <= cnt_q - PW'(1);
                fen   <= 1'b0;
            end
        end else begin
            fen <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_rld_ctrl.sv
// Top level: decodes reset/load commands for channels X (0) and Y (1).
// Registers the action strobes and instantiates the channel datapaths
// and prescalers. All outputs are registered.
module dual_rld_ctrl
    import dual_rld_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 24,
    parameter int PW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          sel_y,
    input  logic [NCH-1:0]                step,
    input  logic                          fck_tick,
    input  logic [NCH-1:0][CW-1:0]        preset,
    output logic [NCH-1:0][NUM_ACT-1:0]   act_q,
    output logic [NCH-1:0][CW-1:0]        cntr_q,
    output logic [NCH-1:0][CW-1:0]        latch_q,
    output logic [NCH-1:0]                fen
);
    act_t [NCH-1:0] act;

    dual_rld_decode #(.DW(DW)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sel_y   (sel_y),
        .act     (act)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Register the strobes so they are one-cycle pulses
        always_ff @(posedge clk) begin
            if (!rst_n) act_q[c] <= '0;
            else        act_q[c] <= act[c];
        end

        dual_rld_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .act     (act[c]),
            .step    (step[c]),
            .preset  (preset[c]),
            .cntr_q  (cntr_q[c]),
            .latch_q (latch_q[c])
        );

        dual_rld_prescale #(.PW(PW)) u_psc (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (act[c].ld_psc),
            .load_val (preset[c][PW-1:0]),
            .tick     (fck_tick),
            .fen      (fen[c])
        );
    end
endmodule

// File: rtl/dual_rld_ctrl_chk.sv
// Assertion checker bound to dual_rld_ctrl.
module dual_rld_ctrl_chk
    import dual_rld_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 24
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [DW-1:0]               wr_data,
    input logic                        sel_y,
    input logic                        fck_tick,
    input logic [NCH-1:0][NUM_ACT-1:0] act_q,
    input logic [NCH-1:0][CW-1:0]      cntr_q,
    input logic [NCH-1:0][CW-1:0]      latch_q,
    input logic [NCH-1:0]              fen
);
    logic grp;
    assign grp = wr_en && (wr_data[6:5] == 2'b00);

    // R2: a broadcast write gives identical strobes on both channels
    a_r2_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (grp && wr_data[7]) |=> (act_q[0] == act_q[1]));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R1: other groups and idle cycles raise no strobe
        a_r1_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (!grp) |=> (act_q[c] == '0));
        // R2: a channel that is not selected stays quiet
        a_r2_unselected: assert property (@(posedge clk) disable iff (!rst_n)
            (grp && !wr_data[7] && (sel_y != 1'(c))) |=> (act_q[c] == '0));
        // R4: the counter-clear strobe comes with a zero counter
        a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            act_q[c][1] |-> (cntr_q[c] == '0));
        // R4/R5: each encoded field raises at most one strobe
        a_r5_field_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(act_q[c][3:1]) && $onehot0(act_q[c][6:4]));
        // R7: the latch holds the counter value from before the edge
        a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
            act_q[c][5] |-> (latch_q[c] == $past(cntr_q[c])));
        // R10: an enable pulse always follows a tick edge
        a_r10_tick: assert property (@(posedge clk) disable iff (!rst_n)
            fen[c] |-> $past(fck_tick));
    end
endmodule

bind dual_rld_ctrl dual_rld_ctrl_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sel_y    (sel_y),
    .fck_tick (fck_tick),
    .act_q    (act_q),
    .cntr_q   (cntr_q),
    .latch_q  (latch_q),
    .fen      (fen)
);

// File: tb/dual_rld_ctrl_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module dual_rld_ctrl_bench;
    localparam int CW = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              sel_y = 1'b0;
    logic [1:0]        step = '0;
    logic              fck_tick = 1'b0;
    logic [1:0][CW-1:0] preset;
    logic [1:0][6:0]    act_q;
    logic [1:0][CW-1:0] cntr_q;
    logic [1:0][CW-1:0] latch_q;
    logic [1:0]         fen;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    // reference model state
    logic [CW-1:0] m_cnt [2];
    logic [CW-1:0] m_lat [2];
    logic [6:0]    m_act [2];
    int            m_n   [2];
    int            m_pc  [2];
    bit            m_fen [2];

    always #2.5 clk = ~clk;

    dual_rld_ctrl u_dual_rld_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sel_y(sel_y), .step(step), .fck_tick(fck_tick), .preset(preset),
        .act_q(act_q), .cntr_q(cntr_q), .latch_q(latch_q), .fen(fen)
    );

    task automatic check(input string tag, input longint actual, input longint expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, actual, expected, $time);
        end
    endtask

    // reference model update at each rising edge
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            logic [6:0] a;
            logic [CW-1:0] old;
            a = '0;
            if (!rst_n) begin
                m_cnt[c] = '0; m_lat[c] = '0; m_act[c] = '0;
                m_n[c] = 0; m_pc[c] = 0; m_fen[c] = 0;
            end else begin
                if (wr_en && wr_data[6:5] == 2'b00 && (wr_data[7] || (sel_y == c[0]))) begin
                    a[0] = wr_data[0];
                    if (wr_data[2:1] != 0) a[wr_data[2:1]] = 1'b1;
                    if (wr_data[4:3] != 0) a[3 + wr_data[4:3]] = 1'b1;
                end
                old = m_cnt[c];
                if (a[5]) m_lat[c] = old;
                if (a[1])         m_cnt[c] = '0;
                else if (a[4])    m_cnt[c] = preset[c];
                else if (step[c]) m_cnt[c] = old + 1;
                if (a[6]) begin
                    m_n[c] = int'(preset[c][7:0]); m_pc[c] = m_n[c]; m_fen[c] = 0;
                end else if (fck_tick) begin
                    if (m_pc[c] == 0) begin m_fen[c] = 1; m_pc[c] = m_n[c]; end
                    else begin m_pc[c] = m_pc[c] - 1; m_fen[c] = 0; end
                end else m_fen[c] = 0;
                m_act[c] = a;
            end
        end
    end

    // compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (model_on && !done) begin
            for (int c = 0; c < 2; c++) begin
                check("R9 strobes vs model", act_q[c], m_act[c]);
                check("R6 counter vs model", cntr_q[c], m_cnt[c]);
                check("R7 latch vs model", latch_q[c], m_lat[c]);
                check("R10 enable vs model", fen[c], m_fen[c]);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // drive one cycle of inputs, return at the next falling edge
    task automatic drive(input bit we, input logic [7:0] d, input bit y,
                         input logic [1:0] st, input bit tk);
        wr_en = we; wr_data = d; sel_y = y; step = st; fck_tick = tk;
        @(negedge clk);
    endtask

    initial begin
        int pulses;
        preset[0] = 24'hABCD02;
        preset[1] = 24'h123456;
        @(negedge clk);
        repeat (3) drive(0, 8'h00, 0, 2'b00, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        drive(0, 8'h00, 0, 2'b00, 0);
        // R11 reset state
        check("R11 counter X", cntr_q[0], 0);
        check("R11 latch Y", latch_q[1], 0);
        check("R11 strobes", act_q, 0);
        check("R11 enable", fen, 0);
        // R12 stepping
        repeat (5) drive(0, 8'h00, 0, 2'b01, 0);
        check("R12 counter X after 5 steps", cntr_q[0], 5);
        // R1 other group ignored
        drive(1, 8'h22, 0, 2'b00, 0);
        check("R1 no strobe X", act_q[0], 0);
        check("R1 counter kept", cntr_q[0], 5);
        drive(1, 8'hF9, 1, 2'b00, 0);
        check("R1 group 11 no strobe Y", act_q[1], 0);
        // R7/R8 latch and clear in one write
        drive(1, 8'h12, 0, 2'b00, 0);
        check("R7 latch holds old counter", latch_q[0], 5);
        check("R8 counter cleared", cntr_q[0], 0);
        check("R8 strobes X", act_q[0], 7'b0100010);
        check("R2 Y untouched", act_q[1], 0);
        // R2/R5 select Y, preset load
        drive(1, 8'h08, 1, 2'b00, 0);
        check("R2 counter Y loaded", cntr_q[1], 24'h123456);
        check("R2 counter X unchanged", cntr_q[0], 0);
        check("R5 strobe Y", act_q[1], 7'b0010000);
        // R6 clear beats load
        drive(1, 8'h0A, 0, 2'b00, 0);
        check("R6 clear beats load", cntr_q[0], 0);
        check("R8 both strobes", act_q[0], 7'b0010010);
        // R6 load beats step
        drive(1, 8'h08, 0, 2'b01, 0);
        check("R6 load beats step", cntr_q[0], 24'hABCD02);
        // R3 byte pointer
        drive(1, 8'h01, 0, 2'b00, 0);
        check("R3 bp strobe", act_q[0], 7'b0000001);
        // R4 reset encodings
        drive(1, 8'h04, 0, 2'b00, 0);
        check("R4 flags strobe", act_q[0], 7'b0000100);
        drive(1, 8'h06, 0, 2'b00, 0);
        check("R4 error strobe", act_q[0], 7'b0001000);
        // R2/R8 broadcast overrides select
        drive(1, 8'h97, 1, 2'b00, 0);
        check("R2 broadcast X", act_q[0], 7'b0101001);
        check("R2 broadcast Y", act_q[1], 7'b0101001);
        check("R8 latch X", latch_q[0], 24'hABCD02);
        check("R8 latch Y", latch_q[1], 24'h123456);
        // R9 strobe lasts one cycle
        drive(0, 8'h00, 0, 2'b00, 0);
        check("R9 strobes drop", act_q, 0);
        // R5/R10 prescaler load n=2
        drive(1, 8'h18, 0, 2'b00, 0);
        check("R5 psc strobe", act_q[0], 7'b1000000);
        check("R10 no pulse on load", fen[0], 0);
        pulses = 0;
        for (int i = 0; i < 9; i++) begin
            drive(0, 8'h00, 0, 2'b00, 1);
            if (fen[0]) pulses++;
        end
        check("R10 pulses in 9 ticks", pulses, 3);
        drive(0, 8'h00, 0, 2'b00, 0);
        check("R10 no pulse without tick", fen, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule